// File: doc/BRIEF.md
# Caller-Data Three-Wire Byte Port

This block takes the sampled output bit of a 1200-baud FSK demodulator and recovers asynchronous characters from it. It then hands each byte to a host controller over three wires: a data line, a clock line and an active-low ready line. The serial bit stream is accepted only while the FSK enable input is high and the active-low carrier-detect input is low. Keeping the enable low stops speech and signalling tones from being taken as data.

A single mode input selects how bytes leave the block. With the mode input low, the block drives the clock line. Each recovered data bit is placed on the data line and followed by a clock pulse. Ready then falls once the whole character has been framed, which marks the word boundary. With the mode input high, the clock line is an input. The block buffers the last good byte and pulls ready low. The host then clocks the bits out, least significant first.

An active-low interrupt output merges three sources: the ready line, the ring/line-reversal event line and the guard-qualified tone detect flag.

Top module: `cid_serial_port`

## Requirements
- R1: With `mode_i` low, `dclk_oe_o` is high and the block drives `dclk_o`. With `mode_i` high, `dclk_oe_o` is low, `dclk_o` is held low, and the host clock is taken from `dclk_i`.
- R2: A character is one low start bit, then 8 data bits least significant first, then one high stop bit. Each bit lasts `BIT_CYCLES` clocks. The start bit is confirmed at its midpoint, and every later bit is sampled at its midpoint.
- R3: With `mode_i` low, each recovered data bit appears on `data_o` as soon as it is sampled. One cycle later comes a one-cycle high pulse on `dclk_o`, so a character gives 8 pulses, LSB first.
- R4: With `mode_i` low, a character with a good stop bit pulls `ready_n_o` low after its 8th `dclk_o` pulse. The line stays low for `BIT_CYCLES/2` cycles.
- R5: A character whose stop bit is sampled low is discarded: `ready_n_o` stays high.
- R6: With `mode_i` high, a good character is buffered and `ready_n_o` goes low. `data_o` shows the current bit, starting with the LSB. Each rising edge on `dclk_i` moves it to the next bit.
- R7: With `mode_i` high, `ready_n_o` stays low through the first 7 rising edges of `dclk_i` and returns high at the 8th.
- R8: With `mode_i` high, a new good character that arrives before the buffered one is read replaces it. The read restarts from the new byte's LSB.
- R9: While `fsk_en_i` is low, nothing is received: no `dclk_o` pulses and no ready. Dropping the enable also abandons a character already in progress.
- R10: While `carrier_n_i` is high (no in-band signal), nothing is received.
- R11: `irq_n_o` is low whenever `ready_n_o` is low, `ring_evt_n_i` is low or `tone_std_i` is high. It is high when all three are inactive.
- R12: After reset, `ready_n_o` is high, `dclk_o` is low and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0: block drives the clock; 1: host drives the clock |
| fsk_en_i | input | 1 | FSK reception enable, active high |
| carrier_n_i | input | 1 | Carrier detect from the demodulator, active low |
| rx_bit_i | input | 1 | Sampled demodulated bit |
| dclk_i | input | 1 | Host clock, used when `mode_i` is high |
| ring_evt_n_i | input | 1 | Ring / line-reversal event, active low |
| tone_std_i | input | 1 | Guard-qualified tone detect, active high |
| dclk_o | output | 1 | Block-driven data clock |
| dclk_oe_o | output | 1 | Output enable for the clock pad |
| data_o | output | 1 | Serial data |
| ready_n_o | output | 1 | Data ready, active low |
| irq_n_o | output | 1 | Combined interrupt, active low |

## Verification
Characters with alternating, all-ones, all-zeros and mixed bit patterns are sent in both modes. These patterns expose bit-order and bit-slip errors that a symmetric byte would hide. A character with a low stop bit is sent to separate framing rejection from plain reception. Further characters are sent with the enable low, with the carrier absent, and with the enable dropped part-way through a character, so the two gates and the abort path are each seen on their own. In host mode, two characters are sent back to back without a read to show replacement. Ready is also checked after the seventh and eighth host edges to pin down where it releases.

// File: rtl/cid_port_pkg.sv
package cid_port_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/cid_frame_rx.sv
module cid_frame_rx
    import cid_port_pkg::*;
#(
    parameter int BIT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsk_en,
    input  logic              carrier_n,
    input  logic              rx_bit,
    output logic              bit_stb,
    output logic              bit_val,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int CW   = $clog2(BIT_CYCLES + 1);
    localparam int HALF = BIT_CYCLES / 2;
    localparam int IW   = $clog2(BYTE_W);

    typedef struct packed {
        rx_state_e         st;
        logic [CW-1:0]     cnt;
        logic [IW-1:0]     idx;
        logic [BYTE_W-1:0] shreg;
        logic              prev;
        logic              bit_stb;
        logic              bit_val;
        logic              byte_stb;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d          = q;
        d.bit_stb  = 1'b0;
        d.byte_stb = 1'b0;
        d.prev     = rx_bit;
        if (!fsk_en || carrier_n) begin
            d.st  = RX_IDLE;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                RX_IDLE: begin
                    if (q.prev && !rx_bit) begin
                        d.st  = RX_START;
                        d.cnt = CW'(1);
                        d.idx = '0;
                    end
                end
                RX_START: begin
                    if (q.cnt == CW'(HALF)) begin
                        d.st  = rx_bit ? RX_IDLE : RX_DATA;
                        d.cnt = CW'(1);
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                RX_DATA: begin
                    if (q.cnt == CW'(BIT_CYCLES)) begin
                        d.shreg   = {rx_bit, q.shreg[BYTE_W-1:1]};
                        d.bit_stb = 1'b1;
                        d.bit_val = rx_bit;
                        d.cnt     = CW'(1);
                        d.idx     = q.idx + IW'(1);
                        if (q.idx == IW'(BYTE_W - 1)) d.st = RX_STOP;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                RX_STOP: begin
                    if (q.cnt == CW'(BIT_CYCLES)) begin
                        d.byte_stb = rx_bit;
                        d.st       = RX_IDLE;
                        d.cnt      = '0;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_IDLE, cnt: '0, idx: '0, shreg: '0, prev: 1'b0,
                   bit_stb: 1'b0, bit_val: 1'b0, byte_stb: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign bit_stb  = q.bit_stb;
    assign bit_val  = q.bit_val;
    assign byte_stb = q.byte_stb;
    assign byte_val = q.shreg;
endmodule

// File: rtl/cid_dev_stream.sv
module cid_dev_stream #(
    parameter int DR_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_stb,
    input  logic bit_val,
    input  logic byte_stb,
    output logic dclk,
    output logic data,
    output logic ready_n
);
    localparam int DW = $clog2(DR_CYCLES + 1);

    typedef struct packed {
        logic          data;
        logic          pend;
        logic          dclk;
        logic [DW-1:0] drcnt;
    } dev_t;

    dev_t q, d;

    always_comb begin
        d      = q;
        d.dclk = 1'b0;
        if (!enable) begin
            d.data  = 1'b0;
            d.pend  = 1'b0;
            d.drcnt = '0;
        end else begin
            if (bit_stb) begin
                d.data = bit_val;
                d.pend = 1'b1;
            end else if (q.pend) begin
                d.dclk = 1'b1;
                d.pend = 1'b0;
            end
            if (byte_stb)              d.drcnt = DW'(DR_CYCLES);
            else if (q.drcnt != '0)    d.drcnt = q.drcnt - DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{data: 1'b0, pend: 1'b0, dclk: 1'b0, drcnt: '0};
        else        q <= d;
    end

    assign dclk    = q.dclk;
    assign data    = q.data;
    assign ready_n = (q.drcnt == '0);
endmodule

// File: rtl/cid_host_shift.sv
module cid_host_shift
    import cid_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              host_clk,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_val,
    output logic              data,
    output logic              ready_n
);
    localparam int LW = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic [BYTE_W-1:0] hold;
        logic [LW-1:0]     left;
        logic              prev_clk;
    } host_t;

    host_t q, d;

    always_comb begin
        d          = q;
        d.prev_clk = host_clk;
        if (!enable) begin
            d.left = '0;
        end else if (byte_stb) begin
            d.hold = byte_val;
            d.left = LW'(BYTE_W);
        end else if (q.left != '0 && host_clk && !q.prev_clk) begin
            d.hold = {1'b0, q.hold[BYTE_W-1:1]};
            d.left = q.left - LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{hold: '0, left: '0, prev_clk: 1'b0};
        else        q <= d;
    end

    assign data    = q.hold[0];
    assign ready_n = (q.left == '0);
endmodule

// File: rtl/cid_serial_port.sv
module cid_serial_port
    import cid_port_pkg::*;
#(
    parameter int BIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic fsk_en_i,
    input  logic carrier_n_i,
    input  logic rx_bit_i,
    input  logic dclk_i,
    input  logic ring_evt_n_i,
    input  logic tone_std_i,
    output logic dclk_o,
    output logic dclk_oe_o,
    output logic data_o,
    output logic ready_n_o,
    output logic irq_n_o
);
    localparam int DR_CYCLES = BIT_CYCLES / 2;

    logic              bit_stb, bit_val, byte_stb;
    logic [BYTE_W-1:0] byte_val;
    logic              dev_dclk, dev_data, dev_rdy_n;
    logic              host_data, host_rdy_n;

    cid_frame_rx #(.BIT_CYCLES(BIT_CYCLES)) u_rx (
        .clk(clk), .rst_n(rst_n), .fsk_en(fsk_en_i), .carrier_n(carrier_n_i),
        .rx_bit(rx_bit_i), .bit_stb(bit_stb), .bit_val(bit_val),
        .byte_stb(byte_stb), .byte_val(byte_val)
    );

    cid_dev_stream #(.DR_CYCLES(DR_CYCLES)) u_dev (
        .clk(clk), .rst_n(rst_n), .enable(!mode_i), .bit_stb(bit_stb),
        .bit_val(bit_val), .byte_stb(byte_stb), .dclk(dev_dclk),
        .data(dev_data), .ready_n(dev_rdy_n)
    );

    cid_host_shift u_host (
        .clk(clk), .rst_n(rst_n), .enable(mode_i), .host_clk(dclk_i),
        .byte_stb(byte_stb), .byte_val(byte_val), .data(host_data),
        .ready_n(host_rdy_n)
    );

    assign dclk_oe_o = !mode_i;
    assign dclk_o    = mode_i ? 1'b0 : dev_dclk;
    assign data_o    = mode_i ? host_data : dev_data;
    assign ready_n_o = mode_i ? host_rdy_n : dev_rdy_n;
    assign irq_n_o   = !(!ring_evt_n_i || !ready_n_o || tone_std_i);
endmodule

// File: rtl/cid_port_checker.sv
module cid_port_checker (
    input logic clk,
    input logic rst_n,
    input logic mode_i,
    input logic fsk_en_i,
    input logic dclk_o,
    input logic ready_n_o,
    input logic ring_evt_n_i,
    input logic tone_std_i,
    input logic irq_n_o
);
    AST_IRQ_ON_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_n_o || !ring_evt_n_i || tone_std_i) |-> !irq_n_o); // R11
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_n_o && ring_evt_n_i && !tone_std_i) |-> irq_n_o); // R11
    AST_HOST_NO_DCLK: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |-> !dclk_o); // R1
    AST_DCLK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_o |=> !dclk_o); // R3
    AST_GATED_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsk_en_i && $past(!fsk_en_i) && ready_n_o) |=> ready_n_o); // R9
endmodule

bind cid_serial_port cid_port_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .fsk_en_i(fsk_en_i),
    .dclk_o(dclk_o), .ready_n_o(ready_n_o), .ring_evt_n_i(ring_evt_n_i),
    .tone_std_i(tone_std_i), .irq_n_o(irq_n_o)
);

// File: tb/sim_cid_serial_port.sv
`timescale 1ns/1ps
module sim_cid_serial_port;
    localparam int BITC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_i = 1'b0, fsk_en_i = 1'b0, carrier_n_i = 1'b1, rx_bit_i = 1'b1;
    logic dclk_i = 1'b0, ring_evt_n_i = 1'b1, tone_std_i = 1'b0;
    logic dclk_o, dclk_oe_o, data_o, ready_n_o, irq_n_o;

    int compared = 0, mismatched = 0, cyc = 0;
    logic [7:0] expq[$];
    logic [7:0] mon_sh = '0;
    int pulses = 0, ready_seen = 0, low_len = 0;
    logic prev_dclk = 1'b0, prev_rdy = 1'b1;

    always #2.5 clk = ~clk;

    cid_serial_port #(.BIT_CYCLES(BITC)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .fsk_en_i(fsk_en_i),
        .carrier_n_i(carrier_n_i), .rx_bit_i(rx_bit_i), .dclk_i(dclk_i),
        .ring_evt_n_i(ring_evt_n_i), .tone_std_i(tone_std_i), .dclk_o(dclk_o),
        .dclk_oe_o(dclk_oe_o), .data_o(data_o), .ready_n_o(ready_n_o),
        .irq_n_o(irq_n_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            finish_run();
        end
    end

    // Device-mode monitor: assembles bits on dclk_o rises, compares on ready fall
    always @(negedge clk) begin
        if (!mode_i) begin
            if (dclk_o && !prev_dclk) begin
                mon_sh = {data_o, mon_sh[7:1]};
                pulses++;
            end
            if (!ready_n_o && prev_rdy) begin
                ready_seen++;
                chk("R4 pulses before ready", pulses, 8);
                if (expq.size() == 0) chk("R5 unexpected ready", 1, 0);
                else chk("R3 device byte", mon_sh, expq.pop_front());
                low_len = 0;
            end
            if (!ready_n_o) low_len++;
            if (ready_n_o && !prev_rdy) chk("R4 ready low length", low_len, BITC / 2);
        end
        prev_dclk = dclk_o;
        prev_rdy  = ready_n_o;
    end

    task automatic send_bit(input logic b);
        @(negedge clk) rx_bit_i = b;
        repeat (BITC - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_ok, input logic expect_it);
        pulses = 0;
        ready_seen = 0;
        if (expect_it) expq.push_back(b);
        send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        send_bit(stop_ok);
        send_bit(1'b1);
        repeat (BITC) @(negedge clk);
    endtask

    task automatic host_read();
        logic [7:0] got;
        chk("R6 ready low when buffered", ready_n_o, 0);
        chk("R11 irq from ready", irq_n_o, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) got[i] = data_o;
            dclk_i = 1'b1;
            repeat (2) @(negedge clk);
            dclk_i = 1'b0;
            repeat (2) @(negedge clk);
            if (i == 6) chk("R7 ready held after 7 edges", ready_n_o, 0);
        end
        chk("R7 ready released after 8 edges", ready_n_o, 1);
        if (expq.size() == 0) chk("R6 host read with empty queue", 1, 0);
        else chk("R6 host byte", got, expq.pop_front());
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 ready after reset", ready_n_o, 1);
        chk("R12 dclk after reset", dclk_o, 0);
        chk("R12 irq after reset", irq_n_o, 1);
        chk("R1 clock driven in device mode", dclk_oe_o, 1);

        fsk_en_i = 1'b1;
        carrier_n_i = 1'b0;
        // R2 R3 R4: assorted patterns in device mode
        send_frame(8'hA5, 1'b1, 1'b1);
        send_frame(8'h01, 1'b1, 1'b1);
        send_frame(8'hFF, 1'b1, 1'b1);
        send_frame(8'h00, 1'b1, 1'b1);
        send_frame(8'h3C, 1'b1, 1'b1);
        chk("R2 all device bytes delivered", expq.size(), 0);

        // R5: bad stop bit
        send_frame(8'h5A, 1'b0, 1'b0);
        chk("R5 pulses still issued", pulses, 8);
        chk("R5 no ready on bad stop", ready_seen, 0);

        // R9: enable low
        fsk_en_i = 1'b0;
        send_frame(8'h77, 1'b1, 1'b0);
        chk("R9 no pulses while disabled", pulses, 0);
        chk("R9 no ready while disabled", ready_seen, 0);
        fsk_en_i = 1'b1;

        // R10: carrier absent
        carrier_n_i = 1'b1;
        send_frame(8'h66, 1'b1, 1'b0);
        chk("R10 no pulses without carrier", pulses, 0);
        chk("R10 no ready without carrier", ready_seen, 0);
        carrier_n_i = 1'b0;

        // R9: abort mid-character, then a clean one
        pulses = 0;
        ready_seen = 0;
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        fsk_en_i = 1'b0;
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        chk("R9 aborted character gives no ready", ready_seen, 0);
        fsk_en_i = 1'b1;
        send_frame(8'hC3, 1'b1, 1'b1);
        chk("R9 reception resumes", expq.size(), 0);

        // R11: interrupt sources
        ring_evt_n_i = 1'b0;
        @(negedge clk) chk("R11 irq from ring", irq_n_o, 0);
        ring_evt_n_i = 1'b1;
        tone_std_i = 1'b1;
        @(negedge clk) chk("R11 irq from tone", irq_n_o, 0);
        tone_std_i = 1'b0;
        @(negedge clk) chk("R11 irq released", irq_n_o, 1);

        // Host mode
        mode_i = 1'b1;
        @(negedge clk);
        chk("R1 clock pad released in host mode", dclk_oe_o, 0);
        send_frame(8'hB4, 1'b1, 1'b1);
        chk("R1 no device clock in host mode", pulses, 0);
        host_read();
        send_frame(8'h81, 1'b1, 1'b1);
        host_read();
        // R8: overwrite before read
        send_frame(8'h11, 1'b1, 1'b0);
        send_frame(8'h6E, 1'b1, 1'b1);
        host_read();
        chk("R8 overwrite leaves nothing pending", expq.size(), 0);
        // R5 in host mode
        send_frame(8'h22, 1'b0, 1'b0);
        chk("R5 host bad stop no ready", ready_n_o, 1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule